// File: doc/BRIEF.md
# Audio Error Interpolator with Mute

This block sits between an audio error corrector and a serial audio formatter. It conceals 16-bit stereo samples that the corrector could not repair. Samples arrive one byte at a time. Each byte carries an error pointer, and a sample counts as bad when either of its two bytes is flagged.

Each channel keeps one sample of lookahead, so the next value is known before a decision is made. A good sample passes through unchanged. A lone bad sample is replaced by the mean of its two neighbours. In a run of bad samples, every sample except the last repeats the last good value, and the last one is averaged with the next good sample.

A gain stage follows. It selects one of three settings: pass-through, a -12 dB step (an arithmetic shift right by two), or mute. Mute is either immediate, or, in zero-cross mode, deferred until a sample close to zero appears.

Top module: `audio_conceal`

## Requirements
- R1: Bytes arrive in a fixed rotation: left low byte, left high byte, right low byte, right high byte. The rotation restarts at the left low byte after reset. A sample is {high byte, low byte}. It is bad when `byte_err` was high on either of its bytes.
- R2: Accepting the first sample of a channel after reset produces no output. Each later sample accepted on a channel makes `out_valid` high for one cycle, one clock after the edge that accepted its high byte. That output carries the concealed previous sample of the channel, with `out_right` = 0 for left and 1 for right.
- R3: A good sample is output unchanged when attenuation and mute are off.
- R4: A bad sample with a good sample on each side is output as floor((previous + next) / 2), computed in signed arithmetic.
- R5: In a run of bad samples, each sample except the last is output as the last good value of that channel.
- R6: The last bad sample of a run is output as floor((last good + next good) / 2).
- R7: With `zc_mute_en` = 0, `atten_en` = 0 and `mute_in` = 1, every output is 0.
- R8: With `zc_mute_en` = 1, `atten_en` = 0 and `mute_in` = 1, outputs of a channel pass until one has bits [15:10] all 0 or all 1. That output and every later output of the channel are 0 until `mute_in` falls.
- R9: With `atten_en` = 1, the output is the concealed value shifted right arithmetically by 2, whatever the value of `mute_in`.
- R10: The two channels are concealed independently of each other.
- R11: After reset, `out_valid` is 0 and the last good value of each channel is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| byte_valid | input | 1 | A byte is present this cycle |
| byte_data | input | 8 | Sample byte |
| byte_err | input | 1 | Error pointer for this byte |
| zc_mute_en | input | 1 | Defer muting to a near-zero sample |
| atten_en | input | 1 | Select the -12 dB step |
| mute_in | input | 1 | Mute request |
| out_valid | output | 1 | Concealed sample is present |
| out_right | output | 1 | 0 = left, 1 = right |
| out_sample | output | 16 | Concealed, gain-adjusted sample (two's complement) |

## Verification
Each result is due exactly one clock after the edge that accepts the high byte of the next sample on the same channel. Left results therefore appear after the second byte of a pair, and right results after the fourth.

The bench drives bytes at falling edges. It reads `out_valid`, `out_right` and `out_sample` at the falling edge right after each high-byte edge, so every result is taken in the only cycle where it is valid.

Mute and attenuation controls are changed only between sample pairs. This means the output of each pair is judged against a single, known gain setting.

// File: rtl/conceal_pkg.sv
package conceal_pkg;
    localparam int BYTE_W    = 8;
    localparam int SAMPLE_W  = 2 * BYTE_W;
    localparam int ZC_BITS   = 6;
    localparam int ATT_SHIFT = 2;
    localparam int NCH       = 2;

    typedef logic [SAMPLE_W-1:0] pcm_t;

    typedef struct packed {
        logic right;
        logic bad;
        pcm_t pcm;
    } word_t;

    // floor((a+b)/2) with a one-bit-wider signed sum
    function automatic pcm_t mean_floor(input pcm_t a, input pcm_t b);
        logic signed [SAMPLE_W:0] s;
        s = $signed({a[SAMPLE_W-1], a}) + $signed({b[SAMPLE_W-1], b});
        return s[SAMPLE_W:1];
    endfunction

    function automatic logic near_zero(input pcm_t v);
        return (v[SAMPLE_W-1 -: ZC_BITS] == '0) || (v[SAMPLE_W-1 -: ZC_BITS] == '1);
    endfunction

    function automatic pcm_t att_step(input pcm_t v);
        return pcm_t'($signed(v) >>> ATT_SHIFT);
    endfunction
endpackage

// File: rtl/byte_gather.sv
module byte_gather
    import conceal_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              byte_valid,
    input  logic [BYTE_W-1:0] byte_data,
    input  logic              byte_err,
    output logic              word_valid,
    output word_t             word
);
    logic [1:0]        phase;
    logic [BYTE_W-1:0] low_q;
    logic              low_err_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase     <= '0;
            low_q     <= '0;
            low_err_q <= 1'b0;
        end else if (byte_valid) begin
            phase <= phase + 2'd1;
            if (!phase[0]) begin
                low_q     <= byte_data;
                low_err_q <= byte_err;
            end
        end
    end

    assign word_valid = byte_valid && phase[0];
    assign word.right = phase[1];
    assign word.bad   = byte_err | low_err_q;
    assign word.pcm   = {byte_data, low_q};

    // R1: a high byte never follows a high byte
    p_rotation_r1: assert property (@(posedge clk) disable iff (rst)
        word_valid |=> !word_valid);
endmodule

// File: rtl/conceal_lane.sv
module conceal_lane
    import conceal_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic in_valid,
    input  pcm_t in_pcm,
    input  logic in_bad,
    output logic out_fire,
    output pcm_t out_pcm
);
    logic pend_valid;
    logic pend_bad;
    pcm_t pend_pcm;
    pcm_t held;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_valid <= 1'b0;
            pend_bad   <= 1'b0;
            pend_pcm   <= '0;
            held       <= '0;
        end else if (in_valid) begin
            pend_valid <= 1'b1;
            pend_bad   <= in_bad;
            pend_pcm   <= in_pcm;
            if (pend_valid && !pend_bad)
                held <= pend_pcm;
        end
    end

    assign out_fire = in_valid && pend_valid;

    always_comb begin
        if (!pend_bad)
            out_pcm = pend_pcm;
        else if (in_bad)
            out_pcm = held;
        else
            out_pcm = mean_floor(held, in_pcm);
    end

    // R5: a bad pending sample never replaces the held value
    p_hold_keep_r5: assert property (@(posedge clk) disable iff (rst)
        (in_valid && pend_valid && pend_bad) |=> $stable(held));
endmodule

// File: rtl/level_ctrl.sv
module level_ctrl
    import conceal_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic fire,
    input  logic chan,
    input  pcm_t pcm_in,
    input  logic zc_en,
    input  logic atten_en,
    input  logic mute_in,
    output pcm_t pcm_out
);
    logic [NCH-1:0] zc_hit;
    logic           arm;
    logic           mute_now;

    assign arm = mute_in && !atten_en && zc_en;

    always_ff @(posedge clk) begin
        if (rst || !mute_in)
            zc_hit <= '0;
        else if (fire && arm && near_zero(pcm_in))
            zc_hit[chan] <= 1'b1;
    end

    assign mute_now = mute_in && !atten_en &&
                      (!zc_en || zc_hit[chan] || near_zero(pcm_in));

    always_comb begin
        if (atten_en)
            pcm_out = att_step(pcm_in);
        else if (mute_now)
            pcm_out = '0;
        else
            pcm_out = pcm_in;
    end

    generate
        for (genvar c = 0; c < NCH; c++) begin : g_chk
            // R8: a latched zero-cross mute persists while mute is requested
            p_zc_keep_r8: assert property (@(posedge clk) disable iff (rst)
                (zc_hit[c] && mute_in) |=> zc_hit[c]);
        end
    endgenerate
endmodule

// File: rtl/audio_conceal.sv
module audio_conceal
    import conceal_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              byte_valid,
    input  logic [BYTE_W-1:0] byte_data,
    input  logic              byte_err,
    input  logic              zc_mute_en,
    input  logic              atten_en,
    input  logic              mute_in,
    output logic              out_valid,
    output logic              out_right,
    output logic [SAMPLE_W-1:0] out_sample
);
    logic           word_valid;
    word_t          word;
    logic [NCH-1:0] lane_sel;
    logic [NCH-1:0] fire;
    pcm_t           lane_pcm [NCH];
    pcm_t           sel_pcm;
    pcm_t           lvl_pcm;

    byte_gather u_gather (
        .clk(clk), .rst(rst), .byte_valid(byte_valid), .byte_data(byte_data),
        .byte_err(byte_err), .word_valid(word_valid), .word(word)
    );

    assign lane_sel = {word_valid & word.right, word_valid & ~word.right};

    generate
        for (genvar ch = 0; ch < NCH; ch++) begin : g_lane
            conceal_lane u_lane (
                .clk(clk), .rst(rst), .in_valid(lane_sel[ch]),
                .in_pcm(word.pcm), .in_bad(word.bad),
                .out_fire(fire[ch]), .out_pcm(lane_pcm[ch])
            );
        end
    endgenerate

    assign sel_pcm = word.right ? lane_pcm[1] : lane_pcm[0];

    level_ctrl u_level (
        .clk(clk), .rst(rst), .fire(|fire), .chan(word.right), .pcm_in(sel_pcm),
        .zc_en(zc_mute_en), .atten_en(atten_en), .mute_in(mute_in), .pcm_out(lvl_pcm)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid  <= 1'b0;
            out_right  <= 1'b0;
            out_sample <= '0;
        end else begin
            out_valid <= |fire;
            if (|fire) begin
                out_right  <= word.right;
                out_sample <= lvl_pcm;
            end
        end
    end

    // R2: an output always follows a completed word by one clock
    p_latency_r2: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $past(word_valid));
    // R7: hard mute yields zero
    p_hard_mute_r7: assert property (@(posedge clk) disable iff (rst)
        (out_valid && $past(mute_in && !atten_en && !zc_mute_en)) |-> (out_sample == '0));
    // R9: attenuated output keeps three equal top bits
    p_atten_sign_r9: assert property (@(posedge clk) disable iff (rst)
        (out_valid && $past(atten_en)) |->
        (out_sample[SAMPLE_W-1] == out_sample[SAMPLE_W-2] &&
         out_sample[SAMPLE_W-1] == out_sample[SAMPLE_W-3]));
endmodule

// File: tb/sim_audio_conceal.sv
module sim_audio_conceal;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        byte_valid = 1'b0;
    logic [7:0]  byte_data = '0;
    logic        byte_err = 1'b0;
    logic        zc_mute_en = 1'b0;
    logic        atten_en = 1'b0;
    logic        mute_in = 1'b0;
    logic        out_valid;
    logic        out_right;
    logic [15:0] out_sample;

    int n_run = 0;
    int n_fail = 0;
    logic        gl_v, gr_v;
    logic [15:0] gl, gr;

    always #4 clk = ~clk;

    audio_conceal u0 (
        .clk(clk), .rst(rst), .byte_valid(byte_valid), .byte_data(byte_data),
        .byte_err(byte_err), .zc_mute_en(zc_mute_en), .atten_en(atten_en),
        .mute_in(mute_in), .out_valid(out_valid), .out_right(out_right),
        .out_sample(out_sample)
    );

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; byte_valid = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic put_byte(input logic [7:0] d, input logic e);
        byte_valid = 1'b1; byte_data = d; byte_err = e;
        @(negedge clk);
    endtask

    // err vectors are {high byte err, low byte err}
    task automatic send_pair(input logic [15:0] lv, input logic [1:0] le,
                             input logic [15:0] rv, input logic [1:0] re);
        put_byte(lv[7:0], le[0]);
        put_byte(lv[15:8], le[1]);
        gl_v = out_valid && !out_right; gl = out_sample;
        put_byte(rv[7:0], re[0]);
        put_byte(rv[15:8], re[1]);
        gr_v = out_valid && out_right; gr = out_sample;
        byte_valid = 1'b0;
    endtask

    task automatic t_reset_first();
        do_reset();
        chk("R11 out_valid after reset", {15'd0, out_valid}, 16'd0);
        send_pair(16'h1234, 2'b00, 16'h5678, 2'b00);
        chk("R2 no output on first sample", {14'd0, gl_v, gr_v}, 16'd0);
        send_pair(16'h0001, 2'b00, 16'h0002, 2'b00);
        chk("R1 R3 left pass byte order", gl, 16'h1234);
        chk("R2 left valid", {15'd0, gl_v}, 16'd1);
        chk("R1 R3 right pass byte order", gr, 16'h5678);
        chk("R2 right valid", {15'd0, gr_v}, 16'd1);
    endtask

    task automatic t_isolated();
        do_reset();
        send_pair(16'd100, 2'b00, -16'sd5, 2'b00);
        send_pair(16'd999, 2'b10, 16'd3, 2'b10);
        chk("R3 left good", gl, 16'd100);
        chk("R10 right good", gr, -16'sd5);
        send_pair(16'd300, 2'b00, -16'sd10, 2'b00);
        chk("R4 left mean", gl, 16'd200);
        chk("R4 right mean floor", gr, -16'sd8);
        send_pair(16'd0, 2'b00, 16'd0, 2'b00);
        chk("R3 left after", gl, 16'd300);
        chk("R3 right after", gr, -16'sd10);
    endtask

    task automatic t_burst();
        do_reset();
        send_pair(16'd1000, 2'b00, 16'd7, 2'b00);
        send_pair(16'd77, 2'b10, 16'd7, 2'b00);
        chk("R3 burst lead", gl, 16'd1000);
        send_pair(16'd88, 2'b01, 16'd7, 2'b00);
        chk("R5 hold first", gl, 16'd1000);
        chk("R10 right untouched", gr, 16'd7);
        send_pair(16'd99, 2'b10, 16'd7, 2'b00);
        chk("R5 R1 hold low-byte flag", gl, 16'd1000);
        send_pair(16'd2000, 2'b00, 16'd7, 2'b00);
        chk("R6 last of run", gl, 16'd1500);
        send_pair(16'd0, 2'b00, 16'd7, 2'b00);
        chk("R3 after run", gl, 16'd2000);
        chk("R10 right still", gr, 16'd7);
    endtask

    task automatic t_zero_hold();
        do_reset();
        send_pair(16'd500, 2'b10, 16'd0, 2'b00);
        send_pair(16'd40, 2'b00, 16'd0, 2'b00);
        chk("R11 held starts at zero", gl, 16'd20);
    endtask

    task automatic t_hard_mute();
        do_reset();
        mute_in = 1'b1;
        send_pair(16'h4000, 2'b00, 16'h7FFF, 2'b00);
        send_pair(16'h4000, 2'b00, 16'h7FFF, 2'b00);
        chk("R7 left muted", gl, 16'd0);
        chk("R7 right muted", gr, 16'd0);
        atten_en = 1'b1;
        send_pair(16'd0, 2'b00, 16'd0, 2'b00);
        chk("R9 atten over mute", gl, 16'h1000);
        atten_en = 1'b0; mute_in = 1'b0;
    endtask

    task automatic t_zero_cross();
        do_reset();
        zc_mute_en = 1'b1; mute_in = 1'b1;
        send_pair(16'h4000, 2'b00, 16'h4000, 2'b00);
        send_pair(16'h0100, 2'b00, 16'hFC00, 2'b00);
        chk("R8 left waits", gl, 16'h4000);
        chk("R8 right waits", gr, 16'h4000);
        send_pair(16'h4000, 2'b00, 16'h4000, 2'b00);
        chk("R8 left near zero muted", gl, 16'd0);
        chk("R8 right all ones muted", gr, 16'd0);
        send_pair(16'h1234, 2'b00, 16'h1234, 2'b00);
        chk("R8 left stays muted", gl, 16'd0);
        mute_in = 1'b0;
        send_pair(16'd0, 2'b00, 16'd0, 2'b00);
        chk("R8 released", gl, 16'h1234);
        zc_mute_en = 1'b0;
    endtask

    task automatic t_atten();
        do_reset();
        atten_en = 1'b1;
        send_pair(-16'sd100, 2'b00, 16'd101, 2'b00);
        send_pair(-16'sd1, 2'b00, 16'h7FFF, 2'b00);
        chk("R9 negative", gl, -16'sd25);
        chk("R9 positive", gr, 16'd25);
        send_pair(16'd0, 2'b00, 16'd0, 2'b00);
        chk("R9 minus one", gl, 16'hFFFF);
        chk("R9 full scale", gr, 16'h1FFF);
        atten_en = 1'b0;
    endtask

    initial begin
        t_reset_first();
        t_isolated();
        t_burst();
        t_zero_hold();
        t_hard_mute();
        t_zero_cross();
        t_atten();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule